// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital output side of a 14-bit sampling converter. A start request moves the front end into hold and begins a conversion. The conversion lasts a fixed number of conversion-clock ticks. While it runs, a busy flag is high, and at the end the result register takes a new 14-bit word from a test input. The word leaves on a single data line, most significant bit first, paced by a shift clock. The frame is sixteen shift clocks long: the fourteen result bits followed by zeros. Zeros keep coming for as long as further shift clocks arrive.

The port has two transfer modes. In the overlapped mode, the busy flag serves as the read window. The word shifted out during a conversion is the one from the previous sample, while the new sample is being converted. In the post-conversion mode, an active-low read strobe opens the window. The word shifted out is the one the last conversion just produced.

In both modes the line is undriven outside the read window. This is modelled as a data line plus an output-enable. All inputs, including the shift clock, are sampled on the system clock. The bit presented on the line moves only after a falling shift-clock edge, so it is steady across each rising edge.

Top module: `adc_serial_out`

## Requirements
- R1: After reset, busy is 0, dout_oe is 0, dout is 0, and the held result is zero, so the first post-conversion read returns a zero frame.
- R2: A rising edge on convst while busy is 0 sets busy high one cycle later. Busy stays high until 16 cycles with conv_tick high have been counted while busy. The clock edge that counts the sixteenth tick clears busy and loads the held result from sample_in.
- R3: A rising edge on convst while busy is 1 is ignored. This holds even in the cycle in which the conversion completes: the count and the end of busy are unchanged, and no new conversion follows.
- R4: When the read window opens, dout_oe rises one cycle later and dout shows result bit 13. Each falling shift-clock edge inside the window moves dout to the next lower bit, down to bit 0.
- R5: After bit 0, every further falling shift-clock edge in the window gives a 0 on dout. Positions 15 and 16 of the frame are zeros, and so is any position after 16, without limit.
- R6: dout_oe falls one cycle after the read window closes. While dout_oe is 0, dout is 0.
- R7: When mode is 0 (overlapped), the read window is busy. The frame shifted out is the result held before the conversion in progress began.
- R8: When mode is 1 (post-conversion), the read window is rd_n low. The frame is the result of the most recent completed conversion.
- R9: A rising shift-clock edge never changes dout.
- R10: Shift-clock edges outside the read window have no effect. Every new window starts again at bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0: overlapped transfer during conversion; 1: transfer after conversion |
| convst | input | 1 | Conversion start; acts on its rising edge |
| conv_tick | input | 1 | Conversion-clock enable; one count per cycle high while busy |
| sample_in | input | RES_W | Value taken as the conversion result |
| rd_n | input | 1 | Active-low read strobe (post-conversion mode) |
| sclk | input | 1 | Shift clock level |
| busy | output | 1 | High while a conversion is running |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Output enable of dout (0 means undriven) |

## Verification
Two functions can fall in the same clock edge: a conversion completing on its last counted tick, and a fresh start request. The bench holds conv_tick high every cycle and raises convst so that its rising edge lands on exactly the edge that counts the sixteenth tick. It then requires busy to fall and to stay low, which shows the request was dropped rather than latched. A second meeting point is in overlapped mode: the read window opens in the cycle after the start, and the first bit must come from the old result. The bench judges this by shifting a full frame during each conversion and comparing it with the value converted one conversion earlier.

// File: rtl/adc_sout_pkg.sv
package adc_sout_pkg;

    localparam int DEF_RES_W      = 14;
    localparam int DEF_FRAME_W    = 16;
    localparam int DEF_CONV_TICKS = 16;

    typedef enum logic {
        XFER_DURING = 1'b0,
        XFER_AFTER  = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adc_sout_edge.sv
module adc_sout_edge
    import adc_sout_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output edge_evt_t evt
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= din;
    end

    assign evt.rise = din & ~level_q;
    assign evt.fall = ~din & level_q;

endmodule

// File: rtl/adc_sout_conv_timer.sv
module adc_sout_conv_timer
    import adc_sout_pkg::*;
#(
    parameter int RES_W      = DEF_RES_W,
    parameter int CONV_TICKS = DEF_CONV_TICKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_evt,
    input  logic             tick,
    input  logic [RES_W-1:0] sample_in,
    output logic             busy,
    output logic [RES_W-1:0] result
);

    localparam int               CNT_W = cnt_width(CONV_TICKS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(CONV_TICKS - 1);

    logic [CNT_W-1:0] cnt;
    logic             finish;

    assign finish = busy & tick & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            result <= '0;
        end else if (busy) begin
            if (finish) begin
                busy   <= 1'b0;
                cnt    <= '0;
                result <= sample_in;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end else if (start_evt) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        !busy && start_evt |=> busy);

    p_wait_tick_r2: assert property (@(posedge clk) disable iff (rst)
        busy && !tick |=> busy && $stable(cnt));

    p_result_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(result));

    p_ignore_start_r3: assert property (@(posedge clk) disable iff (rst)
        busy && start_evt && !tick |=> busy && $stable(cnt));

endmodule

// File: rtl/adc_sout_shifter.sv
module adc_sout_shifter
    import adc_sout_pkg::*;
#(
    parameter int RES_W   = DEF_RES_W,
    parameter int FRAME_W = DEF_FRAME_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_act,
    input  edge_evt_t        sclk_evt,
    input  logic [RES_W-1:0] result,
    output logic             dout,
    output logic             dout_oe
);

    localparam int PAD_W = FRAME_W - RES_W;

    logic [FRAME_W-1:0] sreg;
    logic [FRAME_W-1:0] frame_word;
    logic               act_q;
    logic               load;
    logic               shift;

    assign frame_word = FRAME_W'(result) << PAD_W;
    assign load       = rd_act & ~act_q;
    assign shift      = rd_act & act_q & sclk_evt.fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            sreg  <= '0;
        end else begin
            act_q <= rd_act;
            if (load)       sreg <= frame_word;
            else if (shift) sreg <= {sreg[FRAME_W-2:0], 1'b0};
        end
    end

    assign dout_oe = act_q;
    assign dout    = act_q & sreg[FRAME_W-1];

    p_open_msb_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> dout_oe && (dout == $past(result[RES_W-1])));

    p_zero_tail_r5: assert property (@(posedge clk) disable iff (rst)
        act_q && rd_act && (sreg == '0) |=> (sreg == '0));

    p_oe_drop_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_act |=> !dout_oe && !dout);

    p_rise_hold_r9: assert property (@(posedge clk) disable iff (rst)
        rd_act && act_q && sclk_evt.rise |=> $stable(dout));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_act && !act_q |=> $stable(sreg));

endmodule

// File: rtl/adc_serial_out.sv
module adc_serial_out
    import adc_sout_pkg::*;
#(
    parameter int RES_W      = DEF_RES_W,
    parameter int FRAME_W    = DEF_FRAME_W,
    parameter int CONV_TICKS = DEF_CONV_TICKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode,
    input  logic             convst,
    input  logic             conv_tick,
    input  logic [RES_W-1:0] sample_in,
    input  logic             rd_n,
    input  logic             sclk,
    output logic             busy,
    output logic             dout,
    output logic             dout_oe
);

    xfer_mode_e       xfer_mode;
    edge_evt_t        start_evt;
    edge_evt_t        sclk_evt;
    logic [RES_W-1:0] result;
    logic             rd_act;

    assign xfer_mode = xfer_mode_e'(mode);

    adc_sout_edge u_start_edge (
        .clk (clk),
        .rst (rst),
        .din (convst),
        .evt (start_evt)
    );

    adc_sout_edge u_sclk_edge (
        .clk (clk),
        .rst (rst),
        .din (sclk),
        .evt (sclk_evt)
    );

    adc_sout_conv_timer #(
        .RES_W      (RES_W),
        .CONV_TICKS (CONV_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_evt (start_evt.rise),
        .tick      (conv_tick),
        .sample_in (sample_in),
        .busy      (busy),
        .result    (result)
    );

    always_comb begin
        case (xfer_mode)
            XFER_DURING: rd_act = busy;
            default:     rd_act = ~rd_n;
        endcase
    end

    adc_sout_shifter #(
        .RES_W   (RES_W),
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .rd_act   (rd_act),
        .sclk_evt (sclk_evt),
        .result   (result),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    p_window_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (xfer_mode == XFER_DURING) && $stable(mode) && $fell(busy) |=> !dout_oe);

endmodule

// File: tb/test_adc_serial_out.sv
module test_adc_serial_out;

    localparam int RES_W = 14;
    localparam int NT    = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode = 1'b1;
    logic             convst = 1'b0;
    logic             conv_tick = 1'b0;
    logic [RES_W-1:0] sample_in = '0;
    logic             rd_n = 1'b1;
    logic             sclk = 1'b0;
    logic             busy, dout, dout_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_mode = 0;
    int tick_ctr = 0;
    bit finished = 0;

    // bench-side model of the conversion timer (R2, R3)
    bit m_busy = 0;
    int m_cnt = 0;
    bit m_cvq = 0;
    logic [RES_W-1:0] m_res = '0;

    adc_serial_out i_adc_serial_out (
        .clk(clk), .rst(rst), .mode(mode), .convst(convst), .conv_tick(conv_tick),
        .sample_in(sample_in), .rd_n(rd_n), .sclk(sclk),
        .busy(busy), .dout(dout), .dout_oe(dout_oe)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_cvq = 0; m_res = '0;
        end else begin
            if (m_busy) begin
                if (conv_tick) begin
                    if (m_cnt == NT - 1) begin
                        m_busy = 0; m_cnt = 0; m_res = sample_in;
                    end else m_cnt++;
                end
            end else if (convst && !m_cvq) begin
                m_busy = 1; m_cnt = 0;
            end
            m_cvq = convst;
        end
    end

    always @(negedge clk) begin
        if (!rst) chk("R2/R3 busy", {31'd0, busy}, {31'd0, m_busy});
        case (tick_mode)
            1:       conv_tick <= 1'b1;
            2:       conv_tick <= ($urandom % 4) == 0;
            3:       conv_tick <= (tick_ctr % 8) == 0;
            default: conv_tick <= 1'b0;
        endcase
        tick_ctr++;
    end

    task automatic read_frame(input logic [RES_W-1:0] val, input int nbits, input string md);
        for (int k = 0; k < nbits; k++) begin
            logic expb;
            expb = (k < RES_W) ? val[RES_W-1-k] : 1'b0;
            chk((k < RES_W) ? {"R4 ", md} : {"R5 ", md}, {30'd0, dout_oe, dout}, {30'd0, 1'b1, expb});
            sclk = 1'b1;
            @(negedge clk);
            chk({"R9 ", md}, {31'd0, dout}, {31'd0, expb});
            repeat ($urandom % 2) @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
            repeat ($urandom % 2) @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R2 actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [RES_W-1:0] v, prev;
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 oe", {31'd0, dout_oe}, 32'd0);
        chk("R1 dout", {31'd0, dout}, 32'd0);
        rd_n = 1'b0;
        @(negedge clk);
        read_frame('0, 16, "R1 zero");
        rd_n = 1'b1;
        @(negedge clk);

        // R8 post-conversion mode with random ticks and retrigger
        tick_mode = 2;
        for (int i = 0; i < 4; i++) begin
            v = RES_W'($urandom);
            sample_in = v;
            convst = 1'b1; @(negedge clk); convst = 1'b0;
            repeat (3) @(negedge clk);
            convst = 1'b1; @(negedge clk); convst = 1'b0;   // R3 ignored
            wait_idle();
            chk("R6 closed", {30'd0, dout_oe, dout}, 32'd0);
            rd_n = 1'b0; @(negedge clk);
            read_frame(v, 16 + ($urandom % 7), "R8");
            rd_n = 1'b1; @(negedge clk);
            chk("R6 oe drop", {30'd0, dout_oe, dout}, 32'd0);
            for (int p = 0; p < 3; p++) begin              // R10 idle clocks
                sclk = 1'b1; @(negedge clk); sclk = 1'b0; @(negedge clk);
                chk("R10 idle", {30'd0, dout_oe, dout}, 32'd0);
            end
            rd_n = 1'b0; @(negedge clk);
            read_frame(v, 4, "R10 restart");
            rd_n = 1'b1; @(negedge clk);
        end

        // R3 directed: start request on the completing edge
        tick_mode = 1;
        v = RES_W'($urandom);
        sample_in = v;
        @(negedge clk);
        convst = 1'b1; @(negedge clk); convst = 1'b0;
        repeat (15) @(negedge clk);
        convst = 1'b1; @(negedge clk);
        chk("R3 end edge", {31'd0, busy}, 32'd0);
        convst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 no restart", {31'd0, busy}, 32'd0);
        rd_n = 1'b0; @(negedge clk);
        read_frame(v, 14, "R3 result");
        rd_n = 1'b1; @(negedge clk);
        prev = v;

        // R7 overlapped mode: previous sample during conversion
        mode = 1'b0;
        tick_mode = 3;
        for (int i = 0; i < 4; i++) begin
            v = (i == 0) ? '1 : RES_W'($urandom);
            sample_in = v;
            convst = 1'b1; @(negedge clk); convst = 1'b0;
            @(negedge clk);
            chk("R7 window", {31'd0, dout_oe}, 32'd1);
            read_frame(prev, 16, "R7");
            wait_idle();
            @(negedge clk);
            chk("R6 after busy", {30'd0, dout_oe, dout}, 32'd0);
            prev = v;
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule